// File: doc/BRIEF.md
# Load/store byte-mask coalescing unit

This block sits next to a small table of pending memory accesses and turns as many of them as it can into one byte-enabled write or read of a single 16-byte stripe. A 64-byte cache line is held as four such stripes, and each stripe is a one-read, one-write memory. Merging accesses to the same stripe into one byte-enable word lets several queued loads and stores share one memory cycle without a multi-ported array.

The table owner supplies, for every slot, a live flag, the access address from bit 4 upward and a 16-bit byte mask. It also supplies an N×N matrix saying which pairs of slots agree on address bits 13:4. The unit picks the lowest-numbered live slot as the leader. It broadcasts the leader's bits 48:14 to all slots and compares them there. It then grants every live slot whose matrix entry in the leader's row is set and whose upper bits agree. The leader is always granted. The granted masks are ORed into the stripe byte enable.

The result is held in an output register behind a valid/ready handshake. On acceptance, a one-cycle grant pulse names the merged slots so that the owner can retire them. Slots being accepted are left out of the result loaded in the same cycle, so no access is issued twice.

Top module: `lsc_coalesce_top`

## Requirements
- R1: After reset, the valid output, grant vector, grant pulse, byte enable, stripe address and leader index are all zero.
- R2: The leader index is the lowest-numbered slot whose live bit is set among the slots still eligible; no granted slot has a lower index than the leader.
- R3: A non-leader slot j is granted exactly when it is live, matrix bit [leader*N + j] is set, and its address bits 48:14 equal the leader's.
- R4: The leader's own grant bit is always set, whatever the matrix diagonal holds.
- R5: The byte enable is the bitwise OR of the 16-bit masks of all granted slots; bit k enables byte k of the stripe.
- R6: The stripe address output equals the leader's address bits 48:4; its two lowest bits (address bits 5:4) pick one of the four stripes of the line.
- R7: When no eligible slot is live, valid is low and the grant vector and byte enable are zero.
- R8: While valid is high and ready is low, leader, grant, stripe address and byte enable hold their values and valid stays high.
- R9: The grant pulse equals the grant vector in a cycle where valid and ready are both high, and is zero in every other cycle.
- R10: Slots granted in an accepted result are excluded from the result loaded at that same clock edge, even while their live bits are still set.
- R11: When the output stage is empty and some slot is live, valid is high one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_live_i | input | N_ENT | Live flag per slot |
| ent_addr_i | input | N_ENT*45 | Per slot address bits 48:4, slot i at [i*45 +: 45] |
| ent_mask_i | input | N_ENT*16 | Per slot byte mask, slot i at [i*16 +: 16] |
| mid_match_i | input | N_ENT*N_ENT | Pairwise bits 13:4 agreement, row i column j at [i*N_ENT + j] |
| out_ready_i | input | 1 | Consumer accepts the held result |
| out_valid_o | output | 1 | A merged stripe access is held |
| out_leader_o | output | $clog2(N_ENT) | Index of the leader slot |
| out_grant_o | output | N_ENT | Slots merged into the held access |
| out_stripe_addr_o | output | 45 | Leader address bits 48:4 |
| out_byte_en_o | output | 16 | Merged byte enable |
| grant_pulse_o | output | N_ENT | Merged slots, high only in the acceptance cycle |

## Verification
A result is due one rising edge after the table is presented to an empty stage. The result for the remaining slots is due at the very edge that accepts the previous one. The grant pulse is combinational on ready and appears in the cycle before that edge. The bench drives inputs two time units after a rising edge and samples every output on the falling edge. A scoreboard entry is therefore compared in the half-cycle where it must already be present. Hold cycles with ready low re-compare the same queue head, so any drift of the held fields is caught. The bench also checks valid directly on the first falling edge after each load, to pin the one-edge latency.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    // byte lanes in one stripe of a cache line
    localparam int STRIPE_BYTES = 16;
    // stripes per cache line
    localparam int LINE_STRIPES = 4;
    // lowest address bit above the byte offset inside a stripe
    localparam int MID_LO = 4;
    // lowest address bit of the broadcast compare field
    localparam int HI_LO = 14;
    // top address bit carried by a slot
    localparam int ADDR_MSB = 48;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lsc_leader_pick.sv
module lsc_leader_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  live_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  onehot_o
);

    // scan from the top so the lowest live slot is written last
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        onehot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live_i[i]) begin
                found_o  = 1'b1;
                idx_o    = IW'(i);
                onehot_o = N'(1) << i;
            end
        end
    end

endmodule

// File: rtl/lsc_hi_compare.sv
module lsc_hi_compare #(
    parameter int N    = 8,
    parameter int HI_W = 35,
    parameter int IW   = 3
) (
    input  logic [N*HI_W-1:0] hi_i,
    input  logic [IW-1:0]     lead_i,
    output logic [HI_W-1:0]   bcast_o,
    output logic [N-1:0]      eq_o
);

    // broadcast: the leader's upper field driven onto a shared bus
    always_comb begin
        bcast_o = '0;
        for (int i = 0; i < N; i++) begin
            if (IW'(i) == lead_i) begin
                bcast_o = hi_i[i*HI_W +: HI_W];
            end
        end
    end

    // one comparator per slot against the broadcast bus
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq_o[g] = (hi_i[g*HI_W +: HI_W] == bcast_o);
    end

endmodule

// File: rtl/lsc_mask_merge.sv
module lsc_mask_merge #(
    parameter int N  = 8,
    parameter int MW = 16
) (
    input  logic [N-1:0]    grant_i,
    input  logic [N*MW-1:0] mask_i,
    output logic [MW-1:0]   ben_o
);

    logic [MW-1:0] acc [N+1];

    assign acc[0] = '0;

    for (genvar g = 0; g < N; g++) begin : g_or
        assign acc[g+1] = acc[g] | (grant_i[g] ? mask_i[g*MW +: MW] : '0);
    end

    assign ben_o = acc[N];

endmodule

// File: rtl/lsc_coalesce_top.sv
module lsc_coalesce_top #(
    parameter int N_ENT    = 8,
    parameter int ADDR_MSB = lsc_pkg::ADDR_MSB,
    parameter int MASK_W   = lsc_pkg::STRIPE_BYTES
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_ENT-1:0]                ent_live_i,
    input  logic [N_ENT*(ADDR_MSB-lsc_pkg::MID_LO+1)-1:0] ent_addr_i,
    input  logic [N_ENT*MASK_W-1:0]         ent_mask_i,
    input  logic [N_ENT*N_ENT-1:0]          mid_match_i,
    input  logic                            out_ready_i,
    output logic                            out_valid_o,
    output logic [lsc_pkg::idx_width(N_ENT)-1:0] out_leader_o,
    output logic [N_ENT-1:0]                out_grant_o,
    output logic [ADDR_MSB-lsc_pkg::MID_LO:0] out_stripe_addr_o,
    output logic [MASK_W-1:0]               out_byte_en_o,
    output logic [N_ENT-1:0]                grant_pulse_o
);

    localparam int IDX_W  = lsc_pkg::idx_width(N_ENT);
    localparam int SA_W   = ADDR_MSB - lsc_pkg::MID_LO + 1;
    localparam int HI_OFF = lsc_pkg::HI_LO - lsc_pkg::MID_LO;
    localparam int HI_W   = SA_W - HI_OFF;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  leader;
        logic [N_ENT-1:0]  grant;
        logic [SA_W-1:0]   stripe;
        logic [MASK_W-1:0] ben;
    } stage_t;

    stage_t st_d, st_q;

    logic             accept;
    logic [N_ENT-1:0] elig_live;
    logic             lead_found;
    logic [IDX_W-1:0] lead_idx;
    logic [N_ENT-1:0] lead_onehot;
    logic [N_ENT*HI_W-1:0] hi_flat;
    logic [HI_W-1:0]  hi_bcast;
    logic [N_ENT-1:0] hi_eq;
    logic [N_ENT-1:0] mid_row;
    logic [SA_W-1:0]  lead_sa;
    logic [N_ENT-1:0] grant_c;
    logic [MASK_W-1:0] ben_c;

    // a result leaves the stage on this cycle's edge
    assign accept = st_q.valid & out_ready_i;

    // slots leaving now must not be merged again
    assign elig_live = ent_live_i & ~(accept ? st_q.grant : '0);

    for (genvar g = 0; g < N_ENT; g++) begin : g_hi
        assign hi_flat[g*HI_W +: HI_W] = ent_addr_i[g*SA_W + HI_OFF +: HI_W];
    end

    lsc_leader_pick #(
        .N  (N_ENT),
        .IW (IDX_W)
    ) pick_i (
        .live_i   (elig_live),
        .found_o  (lead_found),
        .idx_o    (lead_idx),
        .onehot_o (lead_onehot)
    );

    lsc_hi_compare #(
        .N    (N_ENT),
        .HI_W (HI_W),
        .IW   (IDX_W)
    ) cmp_i (
        .hi_i    (hi_flat),
        .lead_i  (lead_idx),
        .bcast_o (hi_bcast),
        .eq_o    (hi_eq)
    );

    // leader's row of the bits 13:4 agreement matrix, and its stripe address
    always_comb begin
        mid_row = '0;
        lead_sa = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (IDX_W'(i) == lead_idx) begin
                mid_row = mid_match_i[i*N_ENT +: N_ENT];
                lead_sa = ent_addr_i[i*SA_W +: SA_W];
            end
        end
    end

    assign grant_c = elig_live & (lead_onehot | (mid_row & hi_eq));

    lsc_mask_merge #(
        .N  (N_ENT),
        .MW (MASK_W)
    ) merge_i (
        .grant_i (grant_c),
        .mask_i  (ent_mask_i),
        .ben_o   (ben_c)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.valid || accept) begin
            st_d.valid  = lead_found;
            st_d.leader = lead_idx;
            st_d.grant  = grant_c;
            st_d.ben    = ben_c;
            st_d.stripe = lead_found ? lead_sa : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o       = st_q.valid;
    assign out_leader_o      = st_q.leader;
    assign out_grant_o       = st_q.grant;
    assign out_stripe_addr_o = st_q.stripe;
    assign out_byte_en_o     = st_q.ben;
    assign grant_pulse_o     = accept ? st_q.grant : '0;

endmodule

// File: rtl/lsc_coalesce_chk.sv
module lsc_coalesce_chk #(
    parameter int N_ENT = 8,
    parameter int IDX_W = 3,
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_ENT-1:0]  ent_live_i,
    input logic              out_ready_i,
    input logic              out_valid_o,
    input logic [IDX_W-1:0]  out_leader_o,
    input logic [N_ENT-1:0]  out_grant_o,
    input logic [MASK_W-1:0] out_byte_en_o,
    input logic [N_ENT-1:0]  grant_pulse_o
);

    logic [N_ENT-1:0] below_lead;

    always_comb begin
        below_lead = ~({N_ENT{1'b1}} << out_leader_o);
    end

    assert_lowest_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((out_grant_o & below_lead) == '0));

    assert_lead_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> out_grant_o[out_leader_o]);

    assert_idle_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (out_grant_o == '0 && out_byte_en_o == '0));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_grant_o)
            && $stable(out_leader_o) && $stable(out_byte_en_o)));

    assert_pulse_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_pulse_o != '0) |-> (out_valid_o && out_ready_i));

    assert_no_reissue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i) |=> ((out_grant_o & $past(out_grant_o)) == '0));

    assert_load_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid_o && (ent_live_i != '0)) |=> out_valid_o);

endmodule

bind lsc_coalesce_top lsc_coalesce_chk #(
    .N_ENT  (N_ENT),
    .IDX_W  (lsc_pkg::idx_width(N_ENT)),
    .MASK_W (MASK_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ent_live_i    (ent_live_i),
    .out_ready_i   (out_ready_i),
    .out_valid_o   (out_valid_o),
    .out_leader_o  (out_leader_o),
    .out_grant_o   (out_grant_o),
    .out_byte_en_o (out_byte_en_o),
    .grant_pulse_o (grant_pulse_o)
);

// File: tb/lsc_coalesce_top_tb_top.sv
module lsc_coalesce_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int SA_W = 45;

    typedef struct {
        logic [2:0]      leader;
        logic [N-1:0]    grant;
        logic [SA_W-1:0] stripe;
        logic [15:0]     ben;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] live = '0;
    logic [48:0] a_arr [N];
    logic [15:0] m_arr [N];
    logic [N*N-1:0] mm = '0;
    logic ready = 1'b0;

    logic [N*SA_W-1:0] addr_flat;
    logic [N*16-1:0]   mask_flat;

    logic            out_valid;
    logic [2:0]      out_leader;
    logic [N-1:0]    out_grant;
    logic [SA_W-1:0] out_stripe;
    logic [15:0]     out_ben;
    logic [N-1:0]    pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            addr_flat[i*SA_W +: SA_W] = a_arr[i][48:4];
            mask_flat[i*16 +: 16]     = m_arr[i];
        end
    end

    lsc_coalesce_top dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .ent_live_i        (live),
        .ent_addr_i        (addr_flat),
        .ent_mask_i        (mask_flat),
        .mid_match_i       (mm),
        .out_ready_i       (ready),
        .out_valid_o       (out_valid),
        .out_leader_o      (out_leader),
        .out_grant_o       (out_grant),
        .out_stripe_addr_o (out_stripe),
        .out_byte_en_o     (out_ben),
        .grant_pulse_o     (pulse)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [48:0] mk(input logic [34:0] hi, input logic [9:0] mid, input logic [3:0] off);
        return {hi, mid, off};
    endfunction

    task automatic pair(input int i, input int j);
        mm[i*N + j] = 1'b1;
        mm[j*N + i] = 1'b1;
    endtask

    // reference model written from the requirements
    function automatic bit model(input logic [N-1:0] lv, output exp_t e);
        int ld = -1;
        e.leader = '0; e.grant = '0; e.stripe = '0; e.ben = '0;
        for (int i = 0; i < N; i++) if (lv[i] && ld < 0) ld = i;
        if (ld < 0) return 1'b0;
        e.leader = 3'(ld);
        e.stripe = a_arr[ld][48:4];
        for (int j = 0; j < N; j++) begin
            if (lv[j] && (j == ld || (mm[ld*N + j] && a_arr[j][48:14] == a_arr[ld][48:14]))) begin
                e.grant[j] = 1'b1;
                e.ben = e.ben | m_arr[j];
            end
        end
        return 1'b1;
    endfunction

    // driver: entered and left two time units after a rising edge
    task automatic run_table(input int hold);
        exp_t e;
        bit first = 1'b1;
        for (int round = 0; round <= N; round++) begin
            if (!model(live, e)) begin
                if (first) begin @(posedge clk); #2; end
                @(negedge clk);
                chk(out_valid == 1'b0, "R7 valid", 64'(out_valid), 64'd0);
                chk(out_grant == '0, "R7 grant", 64'(out_grant), 64'd0);
                chk(out_ben == '0, "R7 byte_en", 64'(out_ben), 64'd0);
                @(posedge clk); #2;
                return;
            end
            sb_q.push_back(e);
            if (first) begin @(posedge clk); #2; end
            @(negedge clk);
            chk(out_valid == 1'b1, "R11 valid after load", 64'(out_valid), 64'd1);
            @(posedge clk); #2;
            for (int h = 0; h < hold; h++) begin @(posedge clk); #2; end
            ready = 1'b1;
            @(posedge clk); #2;
            ready = 1'b0;
            live = live & ~e.grant;
            first = 1'b0;
        end
    endtask

    // monitor: compares the queue head on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected result", 64'(out_grant), 64'd0);
                end else begin
                    chk(out_leader == sb_q[0].leader, "R2 leader", 64'(out_leader), 64'(sb_q[0].leader));
                    chk(out_grant == sb_q[0].grant, "R3 R4 grant", 64'(out_grant), 64'(sb_q[0].grant));
                    chk(out_ben == sb_q[0].ben, "R5 byte_en", 64'(out_ben), 64'(sb_q[0].ben));
                    chk(out_stripe == sb_q[0].stripe, "R6 stripe", 64'(out_stripe), 64'(sb_q[0].stripe));
                    if (ready) begin
                        chk(pulse == sb_q[0].grant, "R9 pulse on accept", 64'(pulse), 64'(sb_q[0].grant));
                        void'(sb_q.pop_front());
                    end else begin
                        chk(pulse == '0, "R8 R9 pulse while held", 64'(pulse), 64'd0);
                    end
                end
            end else begin
                chk(pulse == '0, "R9 pulse idle", 64'(pulse), 64'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin a_arr[i] = '0; m_arr[i] = '0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", 64'(out_valid), 64'd0);
        chk(out_grant == '0 && pulse == '0, "R1 grant", 64'(out_grant), 64'd0);
        chk(out_ben == '0 && out_stripe == '0 && out_leader == '0, "R1 data", 64'(out_ben), 64'd0);
        @(posedge clk); #2;

        // R4: lone slot, matrix diagonal clear
        a_arr[2] = mk(35'h12345, 10'h3, 4'h0);
        m_arr[2] = 16'h00F0;
        mm = '0;
        live = 8'b0000_0100;
        run_table(0);

        // R5 R6: every slot on one stripe, all agree
        for (int i = 0; i < N; i++) begin
            a_arr[i] = mk(35'h7_0000_0001, 10'h155, 4'(i));
            m_arr[i] = 16'h3 << (2*i);
        end
        mm = '1;
        live = '1;
        run_table(1);

        // R3 R10: upper bits split evens from odds, matrix all set
        for (int i = 0; i < N; i++) begin
            a_arr[i] = mk((i % 2 == 0) ? 35'h1AA : 35'h2BB, 10'h021, 4'h0);
            m_arr[i] = 16'h1 << i;
        end
        a_arr[1][5:4] = 2'd3;
        live = '1;
        run_table(0);

        // R3 R4: equal upper bits, matrix alone decides groups
        for (int i = 0; i < N; i++) begin
            a_arr[i] = mk(35'h0ABC, 10'(i), 4'h0);
            m_arr[i] = 16'h8000 >> i;
        end
        mm = '0;
        pair(0, 3); pair(0, 5); pair(3, 5); pair(1, 2);
        live = '1;
        run_table(2);

        // R7: nothing live
        live = '0;
        run_table(0);

        // R2: leader not at slot zero
        for (int i = 0; i < N; i++) begin
            a_arr[i] = mk(35'h55, 10'h2, 4'h0);
            m_arr[i] = 16'h0101 << i;
        end
        a_arr[5][5:4] = 2'd2;
        mm = '1;
        live = 8'b1010_0000;
        run_table(1);

        // R3: matching slots that are not live stay out
        live = 8'b0001_0110;
        run_table(0);

        repeat (2) @(posedge clk);
        chk(sb_q.size() == 0, "R10 scoreboard drained", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule